// File: doc/BRIEF.md
# Online PLA Crosspoint Fault Locator

This block pins down single crosspoint faults in a two-plane programmable logic array while the array keeps running. On a start pulse it freezes one snapshot of three vectors taken together: the array inputs, the product-term wires and the array outputs. It then compares that snapshot against the fault-free programming of both planes. That programming is kept in two small local memories, each filled through its own write port.

The scan has two passes. The first pass walks the AND-plane store one input column per clock. Only columns whose captured input bit is 0 are examined. The second pass walks the OR-plane store one product row per clock. Only rows whose captured product bit is 1 are examined. Each fault found is handed out as a record through a valid/ready handshake. A record holds a 2-bit fault class, a row index and a column index. The block raises `busy` for the whole scan and gives a one-cycle `done` pulse at the end. The array itself, the logic that decides when to diagnose, and any repair are outside this block.

Top module: `pla_fault_locator`

## Requirements
- R1: During and right after reset, `busy`, `rec_valid` and `done` are 0, and both plane stores read as all zeros.
- R2: A `start` seen while idle captures `snap_in`, `snap_pt` and `snap_out` in that cycle. Later changes to those inputs do not affect the results. A `start` seen while `busy` is ignored and does not lengthen the scan.
- R3: AND pass. For each input column i whose captured input bit is 0, word i of the AND store is read, where bit p means input i is wired to product p. Each product p with stored bit 1 and captured product bit 1 gives a record with kind 00, row = i and col = p.
- R4: In an examined AND column, each product p with stored bit 0 and captured product bit 0 gives a record with kind 01, row = i and col = p. Columns whose captured input bit is 1 give no records.
- R5: OR pass. For each product row p whose captured product bit is 1, word p of the OR store is read, where bit o means product p is wired to output o. Each output o with stored bit 1 and captured output bit 0 gives a record with kind 10, row = p and col = o.
- R6: In an examined OR row, each output o with stored bit 0 and captured output bit 1 gives a record with kind 11, row = p and col = o. Rows whose captured product bit is 0 give no records.
- R7: Records come out in a fixed order: all AND columns in ascending i, then all OR rows in ascending p, and by ascending col within one column or row. A record transfers on a clock edge where `rec_valid` and `rec_ready` are both 1. `rec_valid` is never 1 while idle.
- R8: While `rec_valid` is 1 and `rec_ready` is 0, the record stays valid and its kind, row and col do not change.
- R9: Each column or row position takes max(1, k) cycles, where k is the number of records it produces and `rec_ready` is held at 1. With NI inputs and NP products and no records, `busy` lasts NI+NP cycles. `done` is a one-cycle pulse, raised in the first cycle where `busy` is 0 again.
- R10: Writes to either plane store while `busy` is 1 are dropped. A later scan still uses the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a diagnosis; captures the snapshot when idle |
| snap_in | input | NI | Array input vector to capture |
| snap_pt | input | NP | Product-term vector to capture |
| snap_out | input | NO | Array output vector to capture |
| and_we | input | 1 | AND-store write enable |
| and_waddr | input | clog2(NI) | AND-store column (input index) |
| and_wdata | input | NP | AND-store word, one bit per product |
| or_we | input | 1 | OR-store write enable |
| or_waddr | input | clog2(NP) | OR-store row (product index) |
| or_wdata | input | NO | OR-store word, one bit per output |
| rec_ready | input | 1 | Consumer accepts the current record |
| rec_valid | output | 1 | A fault record is presented |
| rec_kind | output | 2 | Fault class 00/01/10/11 |
| rec_row | output | IW | Input index (AND pass) or product index (OR pass) |
| rec_col | output | IW | Product index (AND pass) or output index (OR pass) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
A `start` driven before clock edge e0 is taken at e0. The first record can be seen in the cycle that follows e0, since the store read and the compare are combinational from the scan index. Each record moves on the edge after the bench raised `rec_ready` next to a visible `rec_valid`, and the next record is visible one cycle later. `done` appears in the cycle after the last position ends. The bench drives every input on the falling edge and reads `rec_valid`, `busy` and `done` on that same falling edge, before it picks a ready value. It compares each accepted record in order with a list built from its own copy of the stores. When ready is held at 1, it also counts the busy cycles against the sum of max(1, k) over all positions.

// File: rtl/pla_diag_pkg.sv
package pla_diag_pkg;

    typedef enum logic [1:0] {
        FK_AND_HIGH = 2'b00,
        FK_AND_LOW  = 2'b01,
        FK_OR_LOW   = 2'b10,
        FK_OR_HIGH  = 2'b11
    } fault_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_AND  = 2'b01,
        ST_OR   = 2'b10
    } scan_state_e;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic int index_width(input int a, input int b, input int c);
        int m;
        m = max_of3(a, b, c);
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/plane_store.sv
module plane_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 12,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] words [DEPTH];
    logic wr_in_range;
    logic rd_in_range;

    always_comb begin
        wr_in_range = ({1'b0, waddr} < (AW+1)'(DEPTH));
        rd_in_range = ({1'b0, raddr} < (AW+1)'(DEPTH));
        rdata = rd_in_range ? words[raddr] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) words[k] <= '0;
        end else if (we && wr_in_range) begin
            words[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/lowest_bit_pick.sv
module lowest_bit_pick #(
    parameter int W  = 12,
    parameter int IW = 4
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] pos
);
    always_comb begin
        found = |vec;
        pos   = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec[k]) pos = IW'(k);
        end
    end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import pla_diag_pkg::*;
#(
    parameter int NI = 8,
    parameter int NP = 12,
    parameter int MW = 12,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [MW-1:0] fault_vec,
    input  logic          rec_ready,
    output logic          busy,
    output logic          or_phase,
    output logic [IW-1:0] scan_idx,
    output logic          rec_valid,
    output logic [IW-1:0] rec_pos,
    output logic [MW-1:0] pos_mask,
    output logic          launch,
    output logic          done
);
    scan_state_e   state;
    logic [MW-1:0] served;
    logic [MW-1:0] remaining;
    logic [MW-1:0] left_after;
    logic          any_left;
    logic          take;
    logic          step;
    logic          at_last;

    lowest_bit_pick #(.W(MW), .IW(IW)) u_pick (
        .vec  (remaining),
        .found(any_left),
        .pos  (rec_pos)
    );

    always_comb begin
        busy       = (state != ST_IDLE);
        or_phase   = (state == ST_OR);
        remaining  = busy ? (fault_vec & ~served) : '0;
        pos_mask   = MW'(1) << rec_pos;
        left_after = remaining & ~pos_mask;
        rec_valid  = any_left;
        take       = rec_valid && rec_ready;
        step       = busy && (!any_left || (take && (left_after == '0)));
        at_last    = or_phase ? (scan_idx == IW'(NP - 1)) : (scan_idx == IW'(NI - 1));
        launch     = (state == ST_IDLE) && start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            scan_idx <= '0;
            served   <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                state    <= ST_AND;
                scan_idx <= '0;
                served   <= '0;
            end else if (busy) begin
                if (take) served <= served | pos_mask;
                if (step) begin
                    served <= '0;
                    if (at_last) begin
                        scan_idx <= '0;
                        if (or_phase) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_OR;
                        end
                    end else begin
                        scan_idx <= scan_idx + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pla_fault_locator.sv
module pla_fault_locator
    import pla_diag_pkg::*;
#(
    parameter int NI = 8,
    parameter int NP = 12,
    parameter int NO = 6
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  start,
    input  logic [NI-1:0]                         snap_in,
    input  logic [NP-1:0]                         snap_pt,
    input  logic [NO-1:0]                         snap_out,
    input  logic                                  and_we,
    input  logic [$clog2(NI)-1:0]                 and_waddr,
    input  logic [NP-1:0]                         and_wdata,
    input  logic                                  or_we,
    input  logic [$clog2(NP)-1:0]                 or_waddr,
    input  logic [NO-1:0]                         or_wdata,
    input  logic                                  rec_ready,
    output logic                                  rec_valid,
    output logic [1:0]                            rec_kind,
    output logic [index_width(NI, NP, NO)-1:0]    rec_row,
    output logic [index_width(NI, NP, NO)-1:0]    rec_col,
    output logic                                  busy,
    output logic                                  done
);
    localparam int AWI = $clog2(NI);
    localparam int AWP = $clog2(NP);
    localparam int MW  = (NP > NO) ? NP : NO;
    localparam int IW  = index_width(NI, NP, NO);

    logic [NI-1:0] cap_in;
    logic [NP-1:0] cap_pt;
    logic [NO-1:0] cap_out;
    logic [NP-1:0] and_pat;
    logic [NO-1:0] or_pat;
    logic [NP-1:0] and_hits;
    logic [NO-1:0] or_hits;
    logic [MW-1:0] fault_vec;
    logic [MW-1:0] pat_ext;
    logic [MW-1:0] pos_mask;
    logic [IW-1:0] scan_idx;
    logic [IW-1:0] rec_pos;
    logic          or_phase;
    logic          launch;
    logic          in_sel;
    logic          pt_sel;
    logic          pat_bit;
    fault_kind_e   kind;

    plane_store #(.DEPTH(NI), .WIDTH(NP), .AW(AWI)) u_and_store (
        .clk  (clk),
        .rst  (rst),
        .we   (and_we && !busy),
        .waddr(and_waddr),
        .wdata(and_wdata),
        .raddr(scan_idx[AWI-1:0]),
        .rdata(and_pat)
    );

    plane_store #(.DEPTH(NP), .WIDTH(NO), .AW(AWP)) u_or_store (
        .clk  (clk),
        .rst  (rst),
        .we   (or_we && !busy),
        .waddr(or_waddr),
        .wdata(or_wdata),
        .raddr(scan_idx[AWP-1:0]),
        .rdata(or_pat)
    );

    scan_sequencer #(.NI(NI), .NP(NP), .MW(MW), .IW(IW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .fault_vec(fault_vec),
        .rec_ready(rec_ready),
        .busy     (busy),
        .or_phase (or_phase),
        .scan_idx (scan_idx),
        .rec_valid(rec_valid),
        .rec_pos  (rec_pos),
        .pos_mask (pos_mask),
        .launch   (launch),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_in  <= '0;
            cap_pt  <= '0;
            cap_out <= '0;
        end else if (launch) begin
            cap_in  <= snap_in;
            cap_pt  <= snap_pt;
            cap_out <= snap_out;
        end
    end

    always_comb begin
        in_sel   = |(cap_in & (NI'(1) << scan_idx));
        pt_sel   = |(cap_pt & (NP'(1) << scan_idx));
        and_hits = ~(and_pat ^ cap_pt);
        or_hits  = or_pat ^ cap_out;
        if (or_phase) begin
            fault_vec = pt_sel ? MW'(or_hits) : '0;
            pat_ext   = MW'(or_pat);
        end else begin
            fault_vec = !in_sel ? MW'(and_hits) : '0;
            pat_ext   = MW'(and_pat);
        end
        pat_bit = |(pat_ext & pos_mask);
        if (or_phase) kind = pat_bit ? FK_OR_LOW : FK_OR_HIGH;
        else          kind = pat_bit ? FK_AND_HIGH : FK_AND_LOW;
        rec_kind = kind;
        rec_row  = scan_idx;
        rec_col  = rec_pos;
    end
endmodule

// File: rtl/pla_fault_locator_checker.sv
module pla_fault_locator_checker #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          rec_ready,
    input logic          rec_valid,
    input logic [1:0]    rec_kind,
    input logic [IW-1:0] rec_row,
    input logic [IW-1:0] rec_col,
    input logic          busy,
    input logic          done
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!busy && !rec_valid && !done)); // R1

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy); // R2

    AST_RECORD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> busy); // R7

    AST_RECORD_HELD: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=>
            (rec_valid && $stable(rec_kind) && $stable(rec_row) && $stable(rec_col))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R9
endmodule

bind pla_fault_locator pla_fault_locator_checker #(.IW(IW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rec_ready(rec_ready),
    .rec_valid(rec_valid),
    .rec_kind (rec_kind),
    .rec_row  (rec_row),
    .rec_col  (rec_col),
    .busy     (busy),
    .done     (done)
);

// File: tb/pla_fault_locator_test.sv
`timescale 1ns/1ps
module pla_fault_locator_test;
    localparam int NI  = 8;
    localparam int NP  = 12;
    localparam int NO  = 6;
    localparam int IW  = 4;
    localparam int AWI = $clog2(NI);
    localparam int AWP = $clog2(NP);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [NI-1:0] snap_in = '0;
    logic [NP-1:0] snap_pt = '0;
    logic [NO-1:0] snap_out = '0;
    logic and_we = 1'b0;
    logic [AWI-1:0] and_waddr = '0;
    logic [NP-1:0] and_wdata = '0;
    logic or_we = 1'b0;
    logic [AWP-1:0] or_waddr = '0;
    logic [NO-1:0] or_wdata = '0;
    logic rec_ready = 1'b1;
    logic rec_valid;
    logic [1:0] rec_kind;
    logic [IW-1:0] rec_row;
    logic [IW-1:0] rec_col;
    logic busy;
    logic done;

    int errors = 0;
    int checks = 0;

    logic [NP-1:0] m_and [NI];
    logic [NO-1:0] m_or [NP];
    int e_kind[$];
    int e_row[$];
    int e_col[$];
    int e_cycles;

    always #2 clk = ~clk;

    pla_fault_locator #(.NI(NI), .NP(NP), .NO(NO)) uut (
        .clk(clk), .rst(rst), .start(start),
        .snap_in(snap_in), .snap_pt(snap_pt), .snap_out(snap_out),
        .and_we(and_we), .and_waddr(and_waddr), .and_wdata(and_wdata),
        .or_we(or_we), .or_waddr(or_waddr), .or_wdata(or_wdata),
        .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_kind(rec_kind),
        .rec_row(rec_row), .rec_col(rec_col), .busy(busy), .done(done)
    );

    function automatic string kind_tag(input int k);
        case (k)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic build_expected(input logic [NI-1:0] vi, input logic [NP-1:0] vp,
                                  input logic [NO-1:0] vo);
        e_kind.delete(); e_row.delete(); e_col.delete();
        e_cycles = 0;
        for (int i = 0; i < NI; i++) begin
            int n = 0;
            if (!vi[i]) begin
                for (int p = 0; p < NP; p++) begin
                    if (m_and[i][p] && vp[p]) begin
                        e_kind.push_back(0); e_row.push_back(i); e_col.push_back(p); n++;
                    end else if (!m_and[i][p] && !vp[p]) begin
                        e_kind.push_back(1); e_row.push_back(i); e_col.push_back(p); n++;
                    end
                end
            end
            e_cycles += (n > 0) ? n : 1;
        end
        for (int p = 0; p < NP; p++) begin
            int n = 0;
            if (vp[p]) begin
                for (int o = 0; o < NO; o++) begin
                    if (m_or[p][o] && !vo[o]) begin
                        e_kind.push_back(2); e_row.push_back(p); e_col.push_back(o); n++;
                    end else if (!m_or[p][o] && vo[o]) begin
                        e_kind.push_back(3); e_row.push_back(p); e_col.push_back(o); n++;
                    end
                end
            end
            e_cycles += (n > 0) ? n : 1;
        end
    endtask

    task automatic write_and(input int i, input logic [NP-1:0] d);
        @(negedge clk);
        and_we = 1'b1; and_waddr = AWI'(i); and_wdata = d;
        @(negedge clk);
        and_we = 1'b0;
        m_and[i] = d;
    endtask

    task automatic write_or(input int p, input logic [NO-1:0] d);
        @(negedge clk);
        or_we = 1'b1; or_waddr = AWP'(p); or_wdata = d;
        @(negedge clk);
        or_we = 1'b0;
        m_or[p] = d;
    endtask

    task automatic run_scan(input logic [NI-1:0] vi, input logic [NP-1:0] vp,
                            input logic [NO-1:0] vo, input int ready_pct,
                            input bit meddle, input string ctx);
        int cycles = 0;
        int got = 0;
        bit held = 0;
        bit done_seen = 0;
        bit r;
        logic [1:0] h_kind;
        logic [IW-1:0] h_row;
        logic [IW-1:0] h_col;
        build_expected(vi, vp, vo);
        @(negedge clk);
        snap_in = vi; snap_pt = vp; snap_out = vo; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (meddle) begin
            snap_in = ~vi; snap_pt = ~vp; snap_out = ~vo;
        end
        for (int guard = 0; guard < 4000 && !done_seen; guard++) begin
            if (done) begin
                done_seen = 1;
                check(!busy, "R9", {ctx, " busy low with done"}, busy, 0);
            end else begin
                if (busy) cycles++;
                if (held) begin
                    check(rec_valid && rec_kind == h_kind && rec_row == h_row && rec_col == h_col,
                          "R8", {ctx, " record held under backpressure"},
                          {rec_valid, rec_kind, rec_row, rec_col},
                          {1'b1, h_kind, h_row, h_col});
                end
                if (meddle) begin
                    start     = (cycles == 3);
                    and_we    = (cycles == 2);
                    and_waddr = '0;
                    and_wdata = ~m_and[0];
                    or_we     = (cycles == 5);
                    or_waddr  = '0;
                    or_wdata  = ~m_or[0];
                end
                r = (($urandom % 100) < ready_pct);
                rec_ready = r;
                if (rec_valid && r) begin
                    if (got < e_kind.size()) begin
                        check(rec_kind == e_kind[got] && rec_row == e_row[got] &&
                              rec_col == e_col[got],
                              meddle ? "R2" : kind_tag(e_kind[got]),
                              {ctx, " record kind/row/col packed"},
                              {rec_kind, rec_row, rec_col},
                              {e_kind[got][1:0], e_row[got][IW-1:0], e_col[got][IW-1:0]});
                    end else begin
                        check(0, "R7", {ctx, " extra record index"}, got, e_kind.size());
                    end
                    got++;
                end
                held = rec_valid && !r;
                h_kind = rec_kind; h_row = rec_row; h_col = rec_col;
                @(negedge clk);
            end
        end
        start = 1'b0; and_we = 1'b0; or_we = 1'b0;
        check(done_seen, "R9", {ctx, " done reached"}, done_seen, 1);
        check(got == e_kind.size(), "R7", {ctx, " record count"}, got, e_kind.size());
        if (ready_pct == 100)
            check(cycles == e_cycles, meddle ? "R2" : "R9", {ctx, " busy cycles"},
                  cycles, e_cycles);
        rec_ready = 1'b1;
        @(negedge clk);
        check(!done, "R9", {ctx, " done is a single pulse"}, done, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed_ignored;
        seed_ignored = $urandom(32'd2718);
        for (int i = 0; i < NI; i++) m_and[i] = '0;
        for (int p = 0; p < NP; p++) m_or[p] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !rec_valid && !done, "R1", "outputs in reset",
              {busy, rec_valid, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !rec_valid && !done, "R1", "outputs after reset",
              {busy, rec_valid, done}, 0);

        // R1 / R4: cleared stores, all inputs low, all products low -> every AND crosspoint flagged 01
        run_scan('0, '0, '0, 100, 0, "R1 cleared-low");
        // R6: skipped AND columns, every OR row examined against zero store -> kind 11 everywhere
        run_scan('1, '1, '1, 100, 0, "R6 all-high");

        for (int s = 0; s < 6; s++) begin
            for (int i = 0; i < NI; i++) write_and(i, NP'($urandom));
            for (int p = 0; p < NP; p++) write_or(p, NO'($urandom));
            run_scan(NI'($urandom), NP'($urandom), NO'($urandom),
                     (s % 2 == 0) ? 100 : 55, 0, "random");
        end

        // R2 / R10: snapshot changed, restart and store writes attempted during scan
        run_scan('0, NP'($urandom) | NP'(1), NO'($urandom), 100, 1, "R10 meddle");
        // R10: rescan reads unchanged stores (column 0 and row 0 both examined)
        run_scan('0, NP'($urandom) | NP'(1), NO'($urandom), 100, 0, "R10 rescan");
        run_scan('0, NP'($urandom) | NP'(1), NO'($urandom), 40, 0, "R8 slow-consumer");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule